// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. On request it lowers the active-low chip select, which makes the converter take a sample. It then generates a burst of 16 serial clock cycles and shifts in a 16-bit frame. The frame holds four leading zero bits followed by the result, MSB first. The leading bits are checked and removed, and the 12-bit result is handed out on a valid/ready port. There is no pipeline latency: each frame returns the result of its own sample.

The converter's power mode depends on where chip select is released within a frame. To send it to sleep, the controller ends a frame early on purpose and discards it. While the converter sleeps, a read request first runs a full dummy frame to wake it. The controller then waits a power-up delay given as a number of clock cycles, and only then runs the real read. Between any two frames, chip select stays high for at least a parameterised quiet time.

Output back-pressure rules: once `sample_valid` is high, it and `sample` hold steady until a cycle in which `sample_ready` is high. The word is taken in that cycle. No new frame begins while a word is waiting, and `busy` stays high during that time. The serial clock half period is `DIV` system clocks. An elaboration-time check keeps the resulting rate between 10 kHz and 20 MHz.

Top module: `adc_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is high, and busy, sample_valid and err are all low. The converter is taken to be awake.
- R2: A read frame holds chip select low for exactly 16 falling edges of the serial clock. Each half period of the serial clock lasts `DIV` system clock cycles, and the serial clock idles high and only toggles while chip select is low.
- R3: The converter presents frame bit k (k = 1 for the MSB) after falling edge k, and the controller captures it on the next rising edge. `sample` equals frame bits 11..0.
- R4: If any of frame bits 15..12 is one, err pulses high for one cycle and no sample is delivered. sample_valid and err are never high together.
- R5: When sample_valid is high and sample_ready is low, sample_valid stays high and sample stays unchanged in the next cycle, with busy held high.
- R6: Chip select stays high for at least `QUIET_CYC` clock cycles between the end of one frame and the start of the next.
- R7: A start with power_down_req high while the converter is awake raises chip select after `PD_EDGE` falling edges (2 to 9), with the serial clock high. That frame delivers neither a sample nor an err, and the converter is then asleep.
- R8: A start while the converter is asleep first runs a 16-edge dummy frame. The dummy frame's data is ignored, even when its leading bits are non-zero. The controller then keeps chip select high for at least `PWRUP_CYC` cycles and runs a read frame that delivers its sample, with no further start needed.
- R9: power_down_req is ignored while the converter is asleep: such a start acts as a wake-up followed by a read.
- R10: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Level request for a frame, taken when idle and the quiet time has elapsed |
| power_down_req | input | 1 | With start, makes the frame a power-down frame |
| busy | output | 1 | High from frame launch until the controller is idle again |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdata | input | 1 | Serial data from the converter |
| sample_valid | output | 1 | Result word is available |
| sample_ready | input | 1 | Consumer accepts the result word |
| sample | output | 12 | Conversion result |
| err | output | 1 | One-cycle pulse on a frame with non-zero leading bits |

## Verification
Two functions can meet in one cycle: acceptance of a result word and the launch of the next frame. This happens when start is held high across several frames and sample_ready stays high. The quiet-time counter and the output handshake then both decide the cycle in which chip select may fall again. The bench keeps start high for three consecutive frames and measures the shortest high time of chip select against `QUIET_CYC`. In a separate test it holds sample_ready low for many cycles while start is pulsed. That test checks that the word stays frozen and that no extra frame appears before or after the word is accepted.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_LOW,
    S_HIGH,
    S_PWRUP,
    S_HOLD
  } rd_state_t;

  typedef enum logic [1:0] {
    K_READ,
    K_WAKE,
    K_SLEEP
  } frame_kind_t;

endpackage

// File: rtl/adc_rd_tick.sv
// Divider: emits one enable pulse every DIV cycles while en is high.
module adc_rd_tick #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  assign tick = en && (cnt == LAST);

  assert_tick_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/adc_rd_timer.sv
// Down counter loaded with COUNT; done while it rests at zero.
module adc_rd_timer #(
  parameter int COUNT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int TW = $clog2(COUNT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= TW'(COUNT);
    else if (cnt != '0)   cnt <= cnt - TW'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adc_rd_shift.sv
// MSB-first serial-in shift register.
module adc_rd_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data <= '0;
    else if (clr) data <= '0;
    else if (en)  data <= {data[W-2:0], din};
  end
endmodule

// File: rtl/adc_reader.sv
module adc_reader
  import adc_rd_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int DIV        = 5,
  parameter int QUIET_CYC  = 10,
  parameter int PWRUP_CYC  = 200,
  parameter int PD_EDGE    = 5,
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 power_down_req,
  output logic                 busy,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  input  logic                 adc_sdata,
  output logic                 sample_valid,
  input  logic                 sample_ready,
  output logic [DATA_BITS-1:0] sample,
  output logic                 err
);
  localparam int SCLK_MAX_HZ = 20_000_000;
  localparam int SCLK_MIN_HZ = 10_000;
  localparam int DIV_MIN     = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int DIV_MAX     = CLK_HZ / (2 * SCLK_MIN_HZ);
  localparam int LEAD_BITS   = FRAME_BITS - DATA_BITS;
  localparam int EW          = $clog2(FRAME_BITS + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(FRAME_BITS);
  localparam logic [EW-1:0] SLEEP_EDGE = EW'(PD_EDGE);

  initial begin
    assert_div_range_R2: assert (DIV >= DIV_MIN && DIV <= DIV_MAX)
      else $error("DIV outside serial clock range");
    assert_pd_edge_range_R7: assert (PD_EDGE >= 2 && PD_EDGE <= 9)
      else $error("PD_EDGE must lie in 2..9");
  end

  rd_state_t             state;
  frame_kind_t           kind;
  logic [EW-1:0]         edges;
  logic                  asleep;
  logic                  tick;
  logic                  q_done;
  logic                  pw_done;
  logic [FRAME_BITS-1:0] frame_data;
  logic                  launch;
  logic                  finish;
  logic                  lead_bad;

  assign launch = ((state == S_IDLE) && start && q_done) ||
                  ((state == S_PWRUP) && pw_done && q_done);
  assign finish = (state == S_HIGH) && tick &&
                  ((edges == LAST_EDGE) || ((kind == K_SLEEP) && (edges == SLEEP_EDGE)));
  assign lead_bad = |frame_data[FRAME_BITS-1 -: LEAD_BITS];
  assign busy = (state != S_IDLE);

  adc_rd_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   ((state == S_SETUP) || (state == S_LOW) || (state == S_HIGH)),
    .tick (tick)
  );

  adc_rd_timer #(.COUNT(QUIET_CYC)) u_quiet (
    .clk  (clk),
    .rst_n(rst_n),
    .load (finish),
    .done (q_done)
  );

  adc_rd_timer #(.COUNT(PWRUP_CYC)) u_pwrup (
    .clk  (clk),
    .rst_n(rst_n),
    .load (finish && (kind == K_WAKE)),
    .done (pw_done)
  );

  adc_rd_shift #(.W(FRAME_BITS)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (launch),
    .en   ((state == S_LOW) && tick),
    .din  (adc_sdata),
    .data (frame_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      kind         <= K_READ;
      edges        <= '0;
      adc_cs_n     <= 1'b1;
      adc_sclk     <= 1'b1;
      asleep       <= 1'b0;
      sample_valid <= 1'b0;
      sample       <= '0;
      err          <= 1'b0;
    end else begin
      err <= 1'b0;
      unique case (state)
        S_IDLE: if (start && q_done) begin
          kind     <= asleep ? K_WAKE : (power_down_req ? K_SLEEP : K_READ);
          adc_cs_n <= 1'b0;
          edges    <= '0;
          state    <= S_SETUP;
        end
        S_SETUP: if (tick) begin
          adc_sclk <= 1'b0;
          edges    <= EW'(1);
          state    <= S_LOW;
        end
        S_LOW: if (tick) begin
          adc_sclk <= 1'b1;
          state    <= S_HIGH;
        end
        S_HIGH: if (finish) begin
          adc_cs_n <= 1'b1;
          unique case (kind)
            K_READ: begin
              if (lead_bad) begin
                err   <= 1'b1;
                state <= S_IDLE;
              end else begin
                sample       <= frame_data[DATA_BITS-1:0];
                sample_valid <= 1'b1;
                state        <= S_HOLD;
              end
            end
            K_WAKE: begin
              asleep <= 1'b0;
              state  <= S_PWRUP;
            end
            default: begin
              asleep <= 1'b1;
              state  <= S_IDLE;
            end
          endcase
        end else if (tick) begin
          adc_sclk <= 1'b0;
          edges    <= edges + EW'(1);
          state    <= S_LOW;
        end
        S_PWRUP: if (pw_done && q_done) begin
          kind     <= K_READ;
          adc_cs_n <= 1'b0;
          edges    <= '0;
          state    <= S_SETUP;
        end
        S_HOLD: if (sample_ready) begin
          sample_valid <= 1'b0;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_quiet_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(q_done));

  assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_sclk) |-> !adc_cs_n);

  assert_edge_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edges <= LAST_EDGE);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !sample_ready) |=> (sample_valid && $stable(sample) && busy));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_valid && err));

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_sleep_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_cs_n) && (kind == K_SLEEP)) |-> ((edges == SLEEP_EDGE) && adc_sclk));

  assert_pwrup_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_PWRUP) && !pw_done) |=> adc_cs_n);

endmodule

// File: tb/adc_reader_bench.sv
`timescale 1ns/1ps
module adc_reader_bench;
  localparam int DIV = 5;
  localparam int QC  = 10;
  localparam int PW  = 200;
  localparam int PD  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pd_req = 1'b0;
  logic busy, cs_n, sclk, valid, err;
  logic sdata = 1'b0;
  logic ready = 1'b1;
  logic [11:0] sample;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_reader #(.DIV(DIV), .QUIET_CYC(QC), .PWRUP_CYC(PW), .PD_EDGE(PD)) u_adc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .power_down_req(pd_req),
    .busy(busy), .adc_cs_n(cs_n), .adc_sclk(sclk), .adc_sdata(sdata),
    .sample_valid(valid), .sample_ready(ready), .sample(sample), .err(err)
  );

  // Converter model: bit k of the frame (MSB = 1) appears after falling edge k.
  logic [15:0] cur_frame = 16'h0, next_frame = 16'h0, then_frame = 16'h0;
  int fall_k = 0, frames = 0, last_falls = 0, prev_falls = 0;

  always @(negedge cs_n) begin
    cur_frame = next_frame;
    next_frame = then_frame;
    fall_k = 0;
    frames++;
    sdata = 1'b0;
  end
  always @(negedge sclk) if (!cs_n) begin
    fall_k++;
    if (fall_k <= 16) sdata = cur_frame[16 - fall_k];
  end
  always @(posedge cs_n) begin
    prev_falls = last_falls;
    last_falls = fall_k;
  end

  // Monitors
  int hi_cnt = 0, last_gap = 0, min_gap = 1000000;
  int run = 0, hp_min = 1000000, hp_max = 0;
  bit seen_tog = 0;
  logic sclk_q = 1'b1, valid_q = 1'b0;
  int err_cycles = 0, valid_rises = 0;

  always @(posedge clk) if (rst_n) begin
    if (cs_n) begin
      hi_cnt++;
      run = 0;
      seen_tog = 0;
    end else begin
      if (hi_cnt != 0) begin
        last_gap = hi_cnt;
        if (hi_cnt < min_gap) min_gap = hi_cnt;
      end
      hi_cnt = 0;
      run++;
      if (sclk != sclk_q) begin
        if (seen_tog) begin
          if (run < hp_min) hp_min = run;
          if (run > hp_max) hp_max = run;
        end
        seen_tog = 1;
        run = 0;
      end
    end
    sclk_q = sclk;
    if (err) err_cycles++;
    if (valid && !valid_q) valid_rises++;
    valid_q = valid;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  task automatic clear_mon();
    hp_min = 1000000; hp_max = 0; min_gap = 1000000;
    err_cycles = 0; valid_rises = 0;
  endtask

  task automatic do_start(input logic with_pd);
    @(negedge clk);
    start = 1'b1; pd_req = with_pd;
    for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
    @(negedge clk);
    start = 1'b0; pd_req = 1'b0;
  endtask

  task automatic wait_out();
    for (int i = 0; i < 3000 && !valid && !err; i++) @(negedge clk);
  endtask

  task automatic wait_idle(input int extra);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sclk", sclk, 1);
    chk("R1 busy", busy, 0);
    chk("R1 valid", valid, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_read(input logic [15:0] f);
    next_frame = f; then_frame = f;
    clear_mon();
    do_start(1'b0);
    wait_out();
    chk("R3 sample", sample, int'(f[11:0]));
    chk("R2 falling edges", last_falls, 16);
    chk("R2 half period min", hp_min, DIV);
    chk("R2 half period max", hp_max, DIV);
    wait_idle(QC + 4);
  endtask

  task automatic t_lead_err();
    next_frame = 16'h8123; then_frame = 16'h8123;
    clear_mon();
    do_start(1'b0);
    wait_idle(5);
    chk("R4 err pulse cycles", err_cycles, 1);
    chk("R4 no valid", valid_rises, 0);
    repeat (QC) @(negedge clk);
  endtask

  task automatic t_backpressure();
    int f0;
    bit held = 1;
    ready = 1'b0;
    next_frame = 16'h0A5C; then_frame = 16'h0A5C;
    do_start(1'b0);
    wait_out();
    f0 = frames;
    for (int i = 0; i < 40; i++) begin
      if (i == 10) start = 1'b1;
      if (i == 12) start = 1'b0;
      @(negedge clk);
      if (!valid || sample != 12'hA5C || !busy) held = 0;
    end
    chk("R5 valid and sample held", int'(held), 1);
    chk("R10 no frame while busy", frames, f0);
    ready = 1'b1;
    @(negedge clk);
    chk("R5 accepted", valid, 0);
    repeat (100) @(negedge clk);
    chk("R10 start ignored", frames, f0);
  endtask

  task automatic t_quiet();
    int f0 = frames;
    next_frame = 16'h0123; then_frame = 16'h0123;
    clear_mon();
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < 3000 && frames < f0 + 3; i++) @(negedge clk);
    start = 1'b0;
    wait_idle(QC + 4);
    chk("R6 three frames", frames, f0 + 3);
    chk_ge("R6 min quiet", min_gap, QC);
    chk("R3 back-to-back sample", valid_rises, 3);
  endtask

  task automatic t_sleep();
    next_frame = 16'h0FFF; then_frame = 16'h0FFF;
    clear_mon();
    do_start(1'b1);
    wait_idle(QC + 4);
    chk("R7 abort edge", last_falls, PD);
    chk("R7 no sample", valid_rises, 0);
    chk("R7 no err", err_cycles, 0);
  endtask

  task automatic t_wake();
    int f0 = frames;
    next_frame = 16'hF00F; then_frame = 16'h0321;
    clear_mon();
    do_start(1'b1);
    wait_out();
    chk("R8 two frames", frames, f0 + 2);
    chk("R8 dummy edges", prev_falls, 16);
    chk_ge("R8 power-up wait", last_gap, PW);
    chk("R9 sample after wake", sample, 12'h321);
    chk("R8 dummy ignored", err_cycles, 0);
    wait_idle(QC + 4);
  endtask

  task automatic t_awake_again();
    int f0 = frames;
    t_read(16'h0777);
    chk("R8 awake single frame", frames, f0 + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read(16'h0ABC);
    t_read(16'h0FFF);
    t_read(16'h0000);
    t_read(16'h0555);
    t_lead_err();
    t_backpressure();
    t_quiet();
    t_sleep();
    t_wake();
    t_awake_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule